// File: doc/BRIEF.md
# Repeat-Mode DMA Address and Count Unit

This unit holds the per-channel address and transfer-count state for a DMA channel. Software loads four registers: a memory address, a transfer counter, a reload value and a control byte. Each completed transfer is signalled on a strobe. On each accepted transfer the unit moves the address by one byte or one word, up or down, and decrements the counter. The counter runs from 1 to 256 transfers.

With repeat enabled, the counter reaches zero and the unit reloads it from the reload register. On the same edge it puts the address back to the value software last wrote, so the same block of transfers runs again for as long as the channel enable stays high. With repeat disabled, the unit stops at terminal count: the internal active flag drops and the unit accepts no more transfers until software reloads the counter. Either way, a one-cycle terminal-count pulse is issued, for example to raise an interrupt.

Top module: `rpt_dma_addr_unit`

## Requirements
- R1: After reset the control register reads 0x00, `active` is 0 and `tc_pulse` is 0. The counter and reload registers have no defined reset value.
- R2: The counter drops by exactly one for each accepted transfer, unless the count reaches zero in repeat mode. A transfer is accepted when `xfer_done`, `chan_en` and `active` are all high.
- R3: On each accepted transfer the address moves by 1, or by 2 when control bit 0 (word size) is set. It moves up, or down when control bit 1 (decrement) is set.
- R4: With control bit 2 (repeat) set, a transfer that brings the count to 0x00 loads the reload register into the counter on the same edge. `tc_pulse` is high for the following cycle, and `active` stays 1.
- R5: On that same edge the address returns to the value of the last software write to the address register.
- R6: A loaded count of 0x00 gives 256 transfers before terminal count.
- R7: While `chan_en` is low, `xfer_done` changes neither the counter nor the address.
- R8: With repeat clear, the transfer that brings the count to 0x00 clears `active` and pulses `tc_pulse`. The counter stays at 0x00 and the address is not restored. Later strobes have no effect.
- R9: A software write to the counter sets `active`. If it falls in the same cycle as an accepted transfer, the written value wins: there is no reload or restore and no `tc_pulse`, but the address still steps.
- R10: Register select codes are 0 = address, 1 = counter, 2 = reload, 3 = control. The control byte is read back as written, and bits 3 to 7 are stored without affecting this unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 addr, 1 count, 2 reload, 3 control) |
| reg_wdata | input | AW | Write data (low 8 bits for 8-bit registers) |
| reg_rdata | output | AW | Read data for the selected register |
| xfer_done | input | 1 | One transfer completed |
| chan_en | input | 1 | Channel enable |
| addr | output | AW | Current memory address |
| count | output | 8 | Current transfer count |
| active | output | 1 | Channel has transfers remaining |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |

## Verification
Two events can fall in the same cycle: a transfer that completes the count, and a software write to the counter. The bench drives `xfer_done` in the same cycle as a counter write, once with the count in mid-run and once with the count at 1, where the terminal edge would otherwise occur. It then expects the written count, a stepped but unrestored address, and no `tc_pulse`. The reload and the address restore also share one edge, so both are sampled in the cycle right after the last transfer.

// File: rtl/rpt_dma_addr_unit.sv
module rpt_dma_addr_unit #(
  parameter int AW = 24,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          xfer_done,
  input  logic          chan_en,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] count,
  output logic          active,
  output logic          tc_pulse
);
  localparam logic [1:0] SEL_ADDR = 2'd0, SEL_CNT = 2'd1, SEL_RLD = 2'd2, SEL_CTL = 2'd3;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] start_addr;
  logic [CW-1:0] reload;
  logic [7:0]    ctrl;

  wire word_sz = ctrl[0];
  wire dec_dir = ctrl[1];
  wire rpt_en  = ctrl[2];

  wire wr_addr = reg_wr && reg_sel == SEL_ADDR;
  wire wr_cnt  = reg_wr && reg_sel == SEL_CNT;
  wire wr_rld  = reg_wr && reg_sel == SEL_RLD;
  wire wr_ctl  = reg_wr && reg_sel == SEL_CTL;

  wire           take     = xfer_done && chan_en && active;
  wire           last     = take && count == CNT_ONE && !wr_cnt;
  wire [AW-1:0]  step     = word_sz ? AW'(2) : AW'(1);
  wire [AW-1:0]  addr_mv  = dec_dir ? addr - step : addr + step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl       <= '0;
      active     <= 1'b0;
      tc_pulse   <= 1'b0;
      addr       <= '0;
      start_addr <= '0;
    end else begin
      tc_pulse <= last;
      if (wr_ctl) ctrl <= reg_wdata[7:0];
      if (wr_addr) begin
        addr       <= reg_wdata;
        start_addr <= reg_wdata;
      end else if (last && rpt_en) begin
        addr <= start_addr;
      end else if (take) begin
        addr <= addr_mv;
      end
      if (wr_cnt) active <= 1'b1;
      else if (last && !rpt_en) active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_rld) reload <= reg_wdata[CW-1:0];
    if (wr_cnt) count <= reg_wdata[CW-1:0];
    else if (last && rpt_en) count <= reload;
    else if (take) count <= count - CNT_ONE;
  end

  always_comb begin
    case (reg_sel)
      SEL_ADDR: reg_rdata = addr;
      SEL_CNT:  reg_rdata = AW'(count);
      SEL_RLD:  reg_rdata = AW'(reload);
      default:  reg_rdata = AW'(ctrl);
    endcase
  end

  // R2
  dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !reg_wr && count != CNT_ONE) |=> count == $past(count) - CNT_ONE);
  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !reg_wr && count == CNT_ONE && rpt_en) |=> (count == $past(reload) && tc_pulse && active));
  // R5
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !reg_wr && count == CNT_ONE && rpt_en) |=> addr == $past(start_addr));
  // R8
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !reg_wr && count == CNT_ONE && !rpt_en) |=> (!active && count == '0 && tc_pulse));
  // R9
  sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_CNT) |=> (count == $past(reg_wdata[CW-1:0]) && active && !tc_pulse));
  // R7
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && !reg_wr) |=> ($stable(count) && $stable(addr)));
endmodule

// File: tb/rpt_dma_addr_unit_tb.sv
module rpt_dma_addr_unit_tb;
  localparam int AW = 24;
  logic clk = 0, rst_n = 0, reg_wr = 0, xfer_done = 0, chan_en = 0;
  logic [1:0] reg_sel = 0;
  logic [AW-1:0] reg_wdata = 0, reg_rdata, addr;
  logic [7:0] count;
  logic active, tc_pulse;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rpt_dma_addr_unit #(.AW(AW), .CW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
    .chan_en(chan_en), .addr(addr), .count(count), .active(active),
    .tc_pulse(tc_pulse));

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(bit wr, logic [1:0] sel, logic [AW-1:0] d, bit x);
    @(negedge clk);
    reg_wr = wr; reg_sel = sel; reg_wdata = d; xfer_done = x;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 0; xfer_done = 0;
  endtask

  task automatic wr(logic [1:0] sel, logic [AW-1:0] d); cyc(1, sel, d, 0); endtask
  task automatic xf(); cyc(0, 0, 0, 1); endtask

  task automatic t_reset();
    reg_sel = 3;
    #1;
    chk("R1 ctrl", reg_rdata, 0);
    chk("R1 active", AW'(active), 0);
    chk("R1 tc", AW'(tc_pulse), 0);
  endtask

  task automatic t_regs();
    wr(3, 24'hA5);
    reg_sel = 3; #1;
    chk("R10 ctrl readback", reg_rdata, 24'hA5);
    wr(2, 24'h3C);
    reg_sel = 2; #1;
    chk("R10 reload readback", reg_rdata, 24'h3C);
  endtask

  task automatic t_repeat_byte();
    chan_en = 1;
    wr(3, 24'h04); wr(0, 24'h1000); wr(2, 3); wr(1, 3);
    chk("R9 active on write", AW'(active), 1);
    xf(); chk("R2 count", AW'(count), 2); chk("R3 addr+1", addr, 24'h1001);
    xf(); chk("R2 count", AW'(count), 1); chk("R3 addr+1", addr, 24'h1002);
    chk("R4 no early tc", AW'(tc_pulse), 0);
    xf();
    chk("R4 reload", AW'(count), 3); chk("R4 tc", AW'(tc_pulse), 1);
    chk("R4 active kept", AW'(active), 1); chk("R5 restore", addr, 24'h1000);
    @(posedge clk); @(negedge clk);
    chk("R4 tc one cycle", AW'(tc_pulse), 0);
    xf(); chk("R4 repeats", AW'(count), 2); chk("R4 repeats addr", addr, 24'h1001);
  endtask

  task automatic t_repeat_word_dec();
    wr(3, 24'h07); wr(0, 24'h2000); wr(2, 2); wr(1, 2);
    xf(); chk("R3 addr-2", addr, 24'h1FFE);
    xf(); chk("R5 restore word", addr, 24'h2000); chk("R4 reload 2", AW'(count), 2);
  endtask

  task automatic t_256();
    wr(3, 24'h04); wr(0, 0); wr(2, 0); wr(1, 0);
    for (int i = 0; i < 255; i++) begin
      xf();
      if (tc_pulse) chk("R6 early tc", AW'(i), 999);
    end
    chk("R6 count 1", AW'(count), 1); chk("R6 addr", addr, 255);
    xf(); chk("R6 tc at 256", AW'(tc_pulse), 1); chk("R6 restore", addr, 0);
    chk("R6 reload 0", AW'(count), 0);
  endtask

  task automatic t_chan_off();
    wr(0, 24'h300); wr(1, 5);
    chan_en = 0;
    xf(); xf();
    chk("R7 count held", AW'(count), 5); chk("R7 addr held", addr, 24'h300);
    chan_en = 1;
  endtask

  task automatic t_single();
    wr(3, 0); wr(0, 24'h50); wr(1, 2);
    xf(); xf();
    chk("R8 tc", AW'(tc_pulse), 1); chk("R8 active clr", AW'(active), 0);
    chk("R8 count 0", AW'(count), 0); chk("R8 no restore", addr, 24'h52);
    xf();
    chk("R8 ignored count", AW'(count), 0); chk("R8 ignored addr", addr, 24'h52);
  endtask

  task automatic t_collide();
    wr(3, 24'h04); wr(0, 24'h400); wr(2, 7); wr(1, 3);
    cyc(1, 1, 5, 1);
    chk("R9 write wins", AW'(count), 5); chk("R9 addr stepped", addr, 24'h401);
    wr(1, 1);
    cyc(1, 1, 9, 1);
    chk("R9 no reload", AW'(count), 9); chk("R9 no tc", AW'(tc_pulse), 0);
    chk("R9 no restore", addr, 24'h402);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset(); t_regs(); t_repeat_byte(); t_repeat_word_dec(); t_256();
    t_chan_off(); t_single(); t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule